// File: doc/BRIEF.md
# I2C Register-Access Master Controller

This block is the only master on an I2C bus. It runs register transactions against a slave with a 7-bit address. The host raises `start_i` for one cycle. With that pulse it gives the direction, a register address and a byte count. The controller then generates all SCL and SDA activity and reports the outcome through a one-cycle `done_o` strobe and an error flag.

A write goes in this order: START, address with W, register address, the data bytes, STOP. A read first sets the slave's register pointer with START, address with W and the register address. A repeated START then turns the bus around, followed by address with R and the incoming bytes. The master acknowledges each read byte except the last one and then issues STOP.

SDA is open-drain: `sda_oe_o` pulls the line low and `sda_o` is tied low. SCL comes from a runtime divider that splits each bit into four equal phases.

The controller is one state machine with these states:
- IDLE
- START
- TX (address, register or write-data byte plus the acknowledge slot)
- RX (read byte plus the acknowledge slot)
- RESTART
- STOP

The transitions are:
- IDLE→START on an accepted request.
- START→TX.
- From TX, each byte end goes to one of three places:
  - TX again for the next byte;
  - RESTART after the register byte of a read;
  - STOP after the last data byte or on a not-acknowledge.
- TX→RX after the read address is acknowledged.
- RX→RX between read bytes.
- RX→STOP after the last read byte.
- RESTART→TX.
- STOP→IDLE, which raises `done_o`.

Top module: `i2c_reg_master`

## Requirements
- R1: Out of reset and whenever idle, `scl_o` is 1, `sda_oe_o` is 0 (SDA released), and `busy_o` and `done_o` are 0.
- R2: One bit lasts 4×(`clk_div_i`+1) system clocks: SCL is low for the first two phases and high for the last two. Within a byte or acknowledge slot, SDA changes only while SCL is low.
- R3: START is SDA falling while SCL is high. STOP is SDA rising while SCL is high. A repeated START has the START form with no STOP in front of it.
- R4: Bytes are sent MSB first. The ninth SCL pulse of each byte is the acknowledge slot, in which low means ACK. The first byte after each START is {address, direction}, where direction 0 is write and 1 is read; with the default address 0x68 these bytes are 0xD0 and 0xD1.
- R5: A write puts this on the bus: START, 0xD0, register address, N data bytes, STOP. A `nbytes_i` of 0 counts as 1. Each data byte is taken from `wdata_i` at the moment it is loaded, and `wtake_o` pulses once in the following cycle so the host can present the next byte.
- R6: A read puts this on the bus: START, 0xD0, register address, repeated START, 0xD1, N received bytes, STOP. There is no STOP between the register byte and the repeated START.
- R7: While receiving, the master drives ACK (SDA low) for each byte except the last and leaves SDA high (NACK) for the last. Each received byte appears on `rdata_o` with a one-cycle `rvalid_o` pulse.
- R8: A NACK on the write address, the register address or the read address causes a STOP and then `done_o`. It also sets `err_o`, which holds until the next accepted request clears it.
- R9: A NACK on a write-data byte stops the remaining bytes, causes a STOP and `done_o`, and leaves `err_o` at 0.
- R10: `start_i` is accepted only in IDLE. A pulse while busy changes neither the bus sequence nor the outputs. `busy_o` rises in the cycle after acceptance and falls when STOP completes, in the same cycle as the single-cycle `done_o` pulse. A request in that cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle transaction request |
| rd_i | input | 1 | 1 = read transaction, 0 = write |
| reg_addr_i | input | 8 | Slave register address |
| wdata_i | input | 8 | Write data byte, sampled at each load |
| nbytes_i | input | CNT_W (4) | Data byte count (0 treated as 1) |
| clk_div_i | input | DIV_W (8) | Phase length minus one, in system clocks |
| wtake_o | output | 1 | Pulse: current `wdata_i` was consumed |
| rdata_o | output | 8 | Last received byte |
| rvalid_o | output | 1 | Pulse: `rdata_o` updated |
| done_o | output | 1 | Pulse: transaction finished |
| err_o | output | 1 | Sticky address/register acknowledge error |
| busy_o | output | 1 | Transaction in progress |
| scl_o | output | 1 | Serial clock |
| sda_i | input | 1 | Sensed SDA level |
| sda_o | output | 1 | SDA drive value (always 0) |
| sda_oe_o | output | 1 | SDA pull-low enable |

## Verification
Two functions can fall in the same cycle: the end of one transaction and the acceptance of the next. The STOP→IDLE transition raises `done_o` in the very cycle in which a new `start_i` may be sampled. The bench raises its next request on the same clock phase where it observes `done_o`, so several transactions run back to back. The scoreboard then requires each new bus sequence to begin with a clean START and `busy_o` to be high again in the following cycle. It also requires the preceding error flag to be cleared by that acceptance and not before.

// File: rtl/i2c_rm_pkg.sv
package i2c_rm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_TX,
        ST_RX,
        ST_RESTART,
        ST_STOP
    } state_t;

    typedef enum logic [1:0] {
        K_ADDR_W,
        K_REG,
        K_DATA,
        K_ADDR_R
    } kind_t;

    localparam int BYTE_W = 8;
endpackage

// File: rtl/i2c_rm_tick.sv
module i2c_rm_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o,
    output logic [1:0]       phase_o
);
    logic [DIV_W-1:0] cnt_q;
    logic [1:0]       phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            phase_q <= 2'd0;
        end else if (!run_i) begin
            cnt_q   <= div_i;
            phase_q <= 2'd0;
        end else if (cnt_q == '0) begin
            cnt_q   <= div_i;
            phase_q <= phase_q + 2'd1;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign tick_o  = run_i && (cnt_q == '0);
    assign phase_o = phase_q;
endmodule

// File: rtl/i2c_rm_shift.sv
module i2c_rm_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    input  logic         shl_i,
    input  logic         sin_en_i,
    input  logic         sin_i,
    output logic [W-1:0] q_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_o <= '0;
        end else if (load_i) begin
            q_o <= val_i;
        end else if (shl_i) begin
            q_o <= {q_o[W-2:0], 1'b0};
        end else if (sin_en_i) begin
            q_o <= {q_o[W-2:0], sin_i};
        end
    end
endmodule

// File: rtl/i2c_reg_master.sv
module i2c_reg_master
    import i2c_rm_pkg::*;
#(
    parameter logic [6:0] SLV_ADDR = 7'h68,
    parameter int         DIV_W    = 8,
    parameter int         CNT_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             rd_i,
    input  logic [7:0]       reg_addr_i,
    input  logic [7:0]       wdata_i,
    input  logic [CNT_W-1:0] nbytes_i,
    input  logic [DIV_W-1:0] clk_div_i,
    output logic             wtake_o,
    output logic [7:0]       rdata_o,
    output logic             rvalid_o,
    output logic             done_o,
    output logic             err_o,
    output logic             busy_o,
    output logic             scl_o,
    input  logic             sda_i,
    output logic             sda_o,
    output logic             sda_oe_o
);
    localparam int          BIT_W    = 4;
    localparam logic [3:0]  ACK_SLOT = 4'd8;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    state_t            state_q, state_d;
    kind_t             kind_q, kind_d;
    logic [BIT_W-1:0]  bit_q, bit_d;
    logic [CNT_W-1:0]  rem_q, rem_d;
    logic              rw_q, rw_d;
    logic [7:0]        reg_q, reg_d;
    logic              nack_q;
    logic              err_q, done_q, wtake_q, rvalid_q;
    logic [7:0]        rdata_q;

    logic              tick, unit_end, samp;
    logic [1:0]        phase;
    logic              ld, shl, sin_en;
    logic [7:0]        ld_val, shreg;
    logic              ack_cap, err_set, err_clr, done_set, wtake_set, rvalid_set;

    i2c_rm_tick #(.DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (state_q != ST_IDLE),
        .div_i   (clk_div_i),
        .tick_o  (tick),
        .phase_o (phase)
    );

    i2c_rm_shift #(.W(BYTE_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (ld),
        .val_i    (ld_val),
        .shl_i    (shl),
        .sin_en_i (sin_en),
        .sin_i    (sda_i),
        .q_o      (shreg)
    );

    assign unit_end = tick && (phase == 2'd3);
    assign samp     = tick && (phase == 2'd2);

    // Next-state and datapath control
    always_comb begin
        state_d    = state_q;
        kind_d     = kind_q;
        bit_d      = bit_q;
        rem_d      = rem_q;
        rw_d       = rw_q;
        reg_d      = reg_q;
        ld         = 1'b0;
        ld_val     = 8'h00;
        shl        = 1'b0;
        sin_en     = 1'b0;
        ack_cap    = 1'b0;
        err_set    = 1'b0;
        err_clr    = 1'b0;
        done_set   = 1'b0;
        wtake_set  = 1'b0;
        rvalid_set = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_START;
                    kind_d  = K_ADDR_W;
                    bit_d   = '0;
                    rem_d   = (nbytes_i == '0) ? ONE : nbytes_i;
                    rw_d    = rd_i;
                    reg_d   = reg_addr_i;
                    ld      = 1'b1;
                    ld_val  = {SLV_ADDR, 1'b0};
                    err_clr = 1'b1;
                end
            end
            ST_START: begin
                if (unit_end) state_d = ST_TX;
            end
            ST_TX: begin
                if (samp && (bit_q == ACK_SLOT)) ack_cap = 1'b1;
                if (unit_end) begin
                    if (bit_q != ACK_SLOT) begin
                        bit_d = bit_q + 1'b1;
                        shl   = 1'b1;
                    end else begin
                        bit_d = '0;
                        if (nack_q) begin
                            state_d = ST_STOP;
                            err_set = (kind_q != K_DATA);
                        end else begin
                            unique case (kind_q)
                                K_ADDR_W: begin
                                    kind_d = K_REG;
                                    ld     = 1'b1;
                                    ld_val = reg_q;
                                end
                                K_REG: begin
                                    if (rw_q) begin
                                        state_d = ST_RESTART;
                                    end else begin
                                        kind_d    = K_DATA;
                                        ld        = 1'b1;
                                        ld_val    = wdata_i;
                                        wtake_set = 1'b1;
                                    end
                                end
                                K_DATA: begin
                                    if (rem_q == ONE) begin
                                        state_d = ST_STOP;
                                    end else begin
                                        rem_d     = rem_q - 1'b1;
                                        ld        = 1'b1;
                                        ld_val    = wdata_i;
                                        wtake_set = 1'b1;
                                    end
                                end
                                K_ADDR_R: begin
                                    state_d = ST_RX;
                                    kind_d  = K_DATA;
                                end
                            endcase
                        end
                    end
                end
            end
            ST_RX: begin
                if (samp && (bit_q != ACK_SLOT)) sin_en = 1'b1;
                if (unit_end) begin
                    if (bit_q != ACK_SLOT) begin
                        bit_d = bit_q + 1'b1;
                    end else begin
                        bit_d      = '0;
                        rvalid_set = 1'b1;
                        if (rem_q == ONE) state_d = ST_STOP;
                        else              rem_d   = rem_q - 1'b1;
                    end
                end
            end
            ST_RESTART: begin
                if (unit_end) begin
                    state_d = ST_TX;
                    kind_d  = K_ADDR_R;
                    ld      = 1'b1;
                    ld_val  = {SLV_ADDR, 1'b1};
                end
            end
            ST_STOP: begin
                if (unit_end) begin
                    state_d  = ST_IDLE;
                    done_set = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            kind_q   <= K_ADDR_W;
            bit_q    <= '0;
            rem_q    <= '0;
            rw_q     <= 1'b0;
            reg_q    <= 8'h00;
            nack_q   <= 1'b0;
            err_q    <= 1'b0;
            done_q   <= 1'b0;
            wtake_q  <= 1'b0;
            rvalid_q <= 1'b0;
            rdata_q  <= 8'h00;
        end else begin
            state_q  <= state_d;
            kind_q   <= kind_d;
            bit_q    <= bit_d;
            rem_q    <= rem_d;
            rw_q     <= rw_d;
            reg_q    <= reg_d;
            done_q   <= done_set;
            wtake_q  <= wtake_set;
            rvalid_q <= rvalid_set;
            if (ack_cap)    nack_q  <= sda_i;
            if (rvalid_set) rdata_q <= shreg;
            if (err_clr)      err_q <= 1'b0;
            else if (err_set) err_q <= 1'b1;
        end
    end

    // Bus outputs
    always_comb begin
        scl_o    = 1'b1;
        sda_oe_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                scl_o    = 1'b1;
                sda_oe_o = 1'b0;
            end
            ST_START: begin
                scl_o    = (phase != 2'd3);
                sda_oe_o = (phase != 2'd0);
            end
            ST_TX: begin
                scl_o    = phase[1];
                sda_oe_o = (bit_q != ACK_SLOT) && !shreg[7];
            end
            ST_RX: begin
                scl_o    = phase[1];
                sda_oe_o = (bit_q == ACK_SLOT) && (rem_q != ONE);
            end
            ST_RESTART: begin
                scl_o    = (phase == 2'd1) || (phase == 2'd2);
                sda_oe_o = phase[1];
            end
            ST_STOP: begin
                scl_o    = (phase != 2'd0);
                sda_oe_o = !phase[1];
            end
            default: begin
                scl_o    = 1'b1;
                sda_oe_o = 1'b0;
            end
        endcase
    end

    assign sda_o    = 1'b0;
    assign busy_o   = (state_q != ST_IDLE);
    assign done_o   = done_q;
    assign err_o    = err_q;
    assign wtake_o  = wtake_q;
    assign rvalid_o = rvalid_q;
    assign rdata_o  = rdata_q;
endmodule

// File: rtl/i2c_reg_master_chk.sv
module i2c_reg_master_chk
    import i2c_rm_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input state_t state,
    input logic   busy,
    input logic   scl,
    input logic   sda_oe,
    input logic   done,
    input logic   err,
    input logic   wtake
);
    logic in_byte;
    assign in_byte = (state == ST_TX) || (state == ST_RX);

    assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (scl && !sda_oe));

    assert_sda_steady_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_byte && $past(in_byte) && scl && $past(scl)) |-> $stable(sda_oe));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_busy_falls_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_err_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> $stable(err));

    assert_wtake_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wtake |-> busy);
endmodule

bind i2c_reg_master i2c_reg_master_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .state  (state_q),
    .busy   (busy_o),
    .scl    (scl_o),
    .sda_oe (sda_oe_o),
    .done   (done_o),
    .err    (err_o),
    .wtake  (wtake_o)
);

// File: tb/i2c_reg_master_bench.sv
module i2c_reg_master_bench;
    localparam logic [15:0] EV_S = 16'h0100;
    localparam logic [15:0] EV_P = 16'h0200;
    localparam logic [15:0] EV_A = 16'h0400;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0, rd_i = 1'b0;
    logic [7:0] reg_addr_i = 8'h00, wdata_i = 8'h00;
    logic [3:0] nbytes_i = 4'd1;
    logic [7:0] clk_div_i = 8'd1;
    logic       wtake_o, rvalid_o, done_o, err_o, busy_o, scl_o, sda_o, sda_oe_o;
    logic [7:0] rdata_o;
    logic       sdrv = 1'b0;
    wire        sda_bus = !(sda_oe_o || sdrv);

    always #4 clk = ~clk;

    i2c_reg_master u_i2c_reg_master (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_i(rd_i),
        .reg_addr_i(reg_addr_i), .wdata_i(wdata_i), .nbytes_i(nbytes_i),
        .clk_div_i(clk_div_i), .wtake_o(wtake_o), .rdata_o(rdata_o),
        .rvalid_o(rvalid_o), .done_o(done_o), .err_o(err_o), .busy_o(busy_o),
        .scl_o(scl_o), .sda_i(sda_bus), .sda_o(sda_o), .sda_oe_o(sda_oe_o)
    );

    int n_cmp = 0, n_bad = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic [7:0]  rd_q[$];
    logic [7:0]  smem[256];
    logic [7:0]  mmem[256];
    logic [7:0]  wlist[3];
    int          widx = 0, wtake_cnt = 0, cyc = 0;
    logic [6:0]  s_addr = 7'h68;
    int          nack_at = -1;

    function automatic void chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endfunction

    function automatic void push(logic [15:0] ev, string tag);
        exp_q.push_back(ev);
        tag_q.push_back(tag);
    endfunction

    function automatic void sb(logic [15:0] ev);
        if (exp_q.size() == 0) begin
            chk("R3 unexpected bus event", {16'h0, ev}, 32'hFFFF);
        end else begin
            automatic string t = tag_q.pop_front();
            chk(t, {16'h0, ev}, {16'h0, exp_q.pop_front()});
        end
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    // Slave model and bus monitor
    logic       p_scl = 1'b1, p_sda = 1'b1, s_scl, s_sda;
    int         cnt = 0, abyte = 0, bidx = 0;
    logic       stx = 1'b0, go_tx = 1'b0, mack = 1'b0, wr_mode = 1'b0, ackv;
    logic [7:0] sh = 8'h00, txb = 8'h00, ptr = 8'h00;

    always @(negedge clk) begin
        s_scl = scl_o;
        s_sda = sda_bus;
        if (rst_n) begin
            if (p_scl && s_scl && p_sda && !s_sda) begin
                sb(EV_S); cnt = 0; abyte = 0; stx = 0; go_tx = 0; sdrv = 0;
            end else if (p_scl && s_scl && !p_sda && s_sda) begin
                sb(EV_P); cnt = 0; stx = 0; go_tx = 0; sdrv = 0; bidx = 0;
            end else if (!p_scl && s_scl) begin
                if (cnt < 8) begin
                    if (!stx) sh = {sh[6:0], s_sda};
                    cnt++;
                end else if (cnt == 8) begin
                    if (stx) begin mack = s_sda; sb(EV_A | {15'h0, s_sda}); end
                    cnt = 9;
                end
            end else if (p_scl && !s_scl) begin
                if (stx && cnt > 0 && cnt < 8) begin
                    sdrv = !txb[7-cnt];
                end else if (cnt == 8) begin
                    if (!stx) begin
                        sb({8'h00, sh});
                        if (abyte == 0) begin
                            ackv = (sh[7:1] == s_addr) && (bidx != nack_at);
                            if (ackv && sh[0]) go_tx = 1;
                            wr_mode = !sh[0];
                        end else begin
                            ackv = (bidx != nack_at);
                            if (ackv) begin
                                if (abyte == 1 && wr_mode) ptr = sh;
                                else begin smem[ptr] = sh; ptr = ptr + 1; end
                            end
                        end
                        sdrv = ackv;
                        abyte++; bidx++;
                    end else sdrv = 0;
                end else if (cnt == 9) begin
                    sdrv = 0; cnt = 0;
                    if (stx) begin
                        ptr = ptr + 1;
                        if (!mack) begin txb = smem[ptr]; sdrv = !txb[7]; end
                        else stx = 0;
                    end else if (go_tx) begin
                        go_tx = 0; stx = 1; txb = smem[ptr]; sdrv = !txb[7];
                    end
                end
            end
        end
        p_scl = s_scl;
        p_sda = s_sda;
    end

    // Read-data and write-take monitors
    always @(negedge clk) begin
        if (rst_n && rvalid_o) begin
            if (rd_q.size() == 0) chk("R7 unexpected rvalid", {24'h0, rdata_o}, 32'hFFFF);
            else chk("R7 read data", {24'h0, rdata_o}, {24'h0, rd_q.pop_front()});
        end
        if (rst_n && wtake_o) begin
            wtake_cnt++;
            widx++;
            if (widx < 3) wdata_i = wlist[widx];
        end
    end

    task automatic pulse_start(input logic rd, input logic [7:0] ra, input int n);
        rd_i = rd; reg_addr_i = ra; nbytes_i = 4'(n); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R10 busy after accept", {31'h0, busy_o}, 32'd1);
    endtask

    task automatic wait_done(output logic err_seen);
        int t;
        t = 0;
        while (!done_o && t < 20000) begin @(negedge clk); t++; end
        chk("R10 done seen", {31'h0, done_o}, 32'd1);
        chk("R10 busy low at done", {31'h0, busy_o}, 32'd0);
        err_seen = err_o;
    endtask

    task automatic run_write(input logic [7:0] ra, input logic [7:0] a, b, c,
                             input int n, input int nk, input logic addr_ok);
        int ne, expw;
        logic experr, e;
        logic [7:0] d[3];
        d[0] = a; d[1] = b; d[2] = c;
        ne = (n == 0) ? 1 : n;
        expw = 0; experr = 0;
        nack_at = nk; s_addr = addr_ok ? 7'h68 : 7'h55;
        push(EV_S, "R3 start"); push(16'h00D0, "R4 write address byte");
        if (!addr_ok || nk == 0) begin
            experr = 1;
        end else begin
            push({8'h00, ra}, "R5 register byte");
            if (nk == 1) experr = 1;
            else begin
                for (int k = 0; k < ne; k++) begin
                    push({8'h00, d[k]}, "R5 data byte");
                    expw = k + 1;
                    if (nk == 2 + k) break;
                    mmem[8'(ra + 8'(k))] = d[k];
                end
            end
        end
        push(EV_P, "R3 stop");
        wlist = d; widx = 0; wdata_i = a; wtake_cnt = 0;
        pulse_start(1'b0, ra, n);
        wait_done(e);
        chk(experr ? "R8 error flag" : "R9 error flag", {31'h0, e}, {31'h0, experr});
        chk("R5 wtake count", wtake_cnt, expw);
        chk("R5 bus sequence complete", exp_q.size(), 0);
    endtask

    task automatic run_read(input logic [7:0] ra, input int n, input int nk);
        int ne;
        logic experr, e;
        ne = (n == 0) ? 1 : n;
        experr = 0;
        nack_at = nk; s_addr = 7'h68;
        push(EV_S, "R3 start"); push(16'h00D0, "R6 write address byte");
        if (nk == 0) experr = 1;
        else begin
            push({8'h00, ra}, "R6 register byte");
            if (nk == 1) experr = 1;
            else begin
                push(EV_S, "R6 repeated start"); push(16'h00D1, "R4 read address byte");
                if (nk == 2) experr = 1;
                else begin
                    for (int k = 0; k < ne; k++) begin
                        push(EV_A | ((k == ne - 1) ? 16'h1 : 16'h0), "R7 master ack bit");
                        rd_q.push_back(mmem[8'(ra + 8'(k))]);
                    end
                end
            end
        end
        push(EV_P, "R3 stop");
        pulse_start(1'b1, ra, n);
        wait_done(e);
        chk("R8 error flag on read", {31'h0, e}, {31'h0, experr});
        chk("R6 bus sequence complete", exp_q.size(), 0);
        chk("R7 all read bytes delivered", rd_q.size(), 0);
    endtask

    task automatic measure_period(input int div);
        int t1, t2;
        while (!busy_o) @(negedge clk);
        while (scl_o) @(negedge clk);
        while (!scl_o) @(negedge clk);
        t1 = cyc;
        while (scl_o) @(negedge clk);
        while (!scl_o) @(negedge clk);
        t2 = cyc;
        chk("R2 bit period", t2 - t1, 4 * (div + 1));
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            smem[i] = 8'(i * 7 + 3);
            mmem[i] = 8'(i * 7 + 3);
        end
        repeat (3) @(negedge clk);
        chk("R1 reset scl", {31'h0, scl_o}, 32'd1);
        chk("R1 reset sda released", {31'h0, sda_oe_o}, 32'd0);
        chk("R1 reset busy", {31'h0, busy_o}, 32'd0);
        chk("R1 reset done", {31'h0, done_o}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        clk_div_i = 8'd1;
        fork
            measure_period(1);
            run_write(8'h10, 8'hA5, 8'h00, 8'h00, 1, -1, 1'b1);
        join
        run_write(8'h20, 8'h11, 8'h22, 8'h33, 3, -1, 1'b1);
        run_read(8'h20, 3, -1);
        run_read(8'h10, 1, -1);
        run_write(8'h30, 8'h7E, 8'h00, 8'h00, 0, -1, 1'b1);
        run_read(8'h30, 1, -1);
        run_write(8'h40, 8'hC1, 8'hC2, 8'hC3, 3, 3, 1'b1);
        run_read(8'h40, 2, -1);
        run_write(8'h50, 8'h01, 8'h02, 8'h03, 2, -1, 1'b0);
        repeat (50) @(negedge clk);
        chk("R8 error sticky while idle", {31'h0, err_o}, 32'd1);
        chk("R1 idle sda released", {31'h0, sda_oe_o}, 32'd0);
        rd_i = 1'b0; reg_addr_i = 8'h60; nbytes_i = 4'd1;
        push(EV_S, "R3 start"); push(16'h00D0, "R4 write address byte");
        push(16'h0060, "R5 register byte"); push(16'h0044, "R5 data byte"); push(EV_P, "R3 stop");
        wlist = '{8'h44, 8'h00, 8'h00}; widx = 0; wdata_i = 8'h44; nack_at = -1; s_addr = 7'h68;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R8 error cleared on accept", {31'h0, err_o}, 32'd0);
        mmem[8'h60] = 8'h44;
        begin
            logic e;
            wait_done(e);
        end
        chk("R5 sequence after error clear", exp_q.size(), 0);
        run_read(8'h70, 2, 1);
        run_read(8'h70, 2, 2);

        fork
            run_write(8'h80, 8'h9A, 8'h9B, 8'h00, 2, -1, 1'b1);
            begin
                repeat (100) @(negedge clk);
                rd_i = 1'b1; reg_addr_i = 8'hEE; start_i = 1'b1;
                @(negedge clk);
                start_i = 1'b0; rd_i = 1'b0; reg_addr_i = 8'h80;
                chk("R10 busy unaffected by request", {31'h0, busy_o}, 32'd1);
            end
        join
        run_read(8'h80, 2, -1);

        clk_div_i = 8'd3;
        fork
            measure_period(3);
            run_read(8'h20, 2, -1);
        join
        repeat (20) @(negedge clk);
        chk("R1 idle scl high", {31'h0, scl_o}, 32'd1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule